// File: doc/BRIEF.md
# Two-Wire Presence-Detect Configuration Memory Slave

This block is a serial slave on a two-wire bus (clock line plus bidirectional data line). It gives a host byte-wide read and write access to a 256-entry configuration memory. A fast system clock oversamples both bus lines through a two-flop synchronizer. The slave pulls the data line low through an active-high enable; the pad and its pull-up sit outside the block.

The slave does nothing on the bus until it sees a start condition. It then compares a 7-bit device address against a fixed 4-bit type code and three strap inputs. A write transfer first loads an internal word pointer and then stores bytes at that pointer. A read transfer streams bytes from the pointer for as long as the host keeps acknowledging. Every stop condition puts the slave into standby, and the standby output reports that state.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset, `standby` is 1 and `sda_pull` is 0.
- R2: Until a start condition is seen, the slave does not pull the data line, whatever is clocked on the bus, and it stays in standby.
- R3: After a start, the first byte is taken MSB first as {type[3:0]=4'b1010, strap[2:0], rw}. On a match, the slave pulls the data line low during the ninth clock. On a mismatch, it does not acknowledge, and it returns to standby and stays mute until the next start.
- R4: In a write transfer (rw=0), the slave acknowledges every further complete byte during its ninth clock.
- R5: In a write, the first byte after the address loads the word pointer. Each later byte is stored at the pointer, and the pointer then increments, wrapping from 255 to 0. A byte cut short by a stop is not stored.
- R6: In a read transfer (rw=1), the slave sends the byte at the pointer MSB first, and the pointer increments after every byte sent, wrapping at 255. A read with no preceding pointer load continues from where the pointer was left.
- R7: After each byte it sends, the slave releases the data line for the ninth clock. If the host acknowledges (drives low), the next byte follows. If not, the slave sends nothing more and waits for a stop.
- R8: A stop condition ends any transfer and sets `standby` to 1.
- R9: A repeated start, with no stop before it, begins a new address phase. This allows a pointer load followed by a read.
- R10: The slave changes `sda_pull` only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap | input | 3 | Low three bits of the device address |
| sda_pull | output | 1 | 1 = pull the data line low |
| standby | output | 1 | 1 = idle after reset, stop or address mismatch |

## Verification
The case to watch is the end of a data byte when a write and a pointer step land on the same edge. The falling clock edge after the eighth bit must store the byte at the old pointer, increment the pointer and raise the acknowledge, all at once. The bench provokes this by writing across the 255 to 0 boundary and then reading those locations back. It judges the result against a model array that the bench fills arithmetically. A read turnaround is judged the same way. There, the pointer step and the release for the host's acknowledge share an edge, and the next read with no pointer load must start at the incremented pointer.

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter int          AW       = 8,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  output logic       sda_pull,
  output logic       standby
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [3:0] {
    S_IDLE     = 4'd0,
    S_DEV      = 4'd1,
    S_DEV_ACK  = 4'd2,
    S_WORD     = 4'd3,
    S_WORD_ACK = 4'd4,
    S_DATA     = 4'd5,
    S_DATA_ACK = 4'd6,
    S_TX       = 4'd7,
    S_TX_ACK   = 4'd8,
    S_WAIT     = 4'd9
  } st_t;

  st_t           state;
  logic [2:0]    scl_sy, sda_sy;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [6:0]    tx;
  logic [AW-1:0] ptr;
  logic          rw, mack;
  logic [7:0]    mem [DEPTH];

  logic scl_q, scl_p, sda_q, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det, we;
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  assign scl_q     = scl_sy[1];
  assign scl_p     = scl_sy[2];
  assign sda_q     = sda_sy[1];
  assign sda_p     = sda_sy[2];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  assign we        = scl_fall & ~start_det & ~stop_det & (state == S_DATA) & (cnt == 4'd8);
  assign rd_byte   = mem[ptr];
  assign standby   = (state == S_IDLE);

  always_ff @(posedge clk)
    if (we) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= S_DEV;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (state == S_DEV || state == S_WORD || state == S_DATA) begin
          sh  <= {sh[6:0], sda_q};
          cnt <= cnt + 4'd1;
        end
        if (state == S_TX) cnt <= cnt + 4'd1;
        if (state == S_TX_ACK) mack <= ~sda_q;
      end
      if (scl_fall) begin
        case (state)
          S_DEV:
            if (cnt == 4'd8) begin
              cnt <= '0;
              if (sh[7:1] == {DEV_TYPE, strap}) begin
                rw       <= sh[0];
                sda_pull <= 1'b1;
                state    <= S_DEV_ACK;
              end else begin
                state <= S_IDLE;
              end
            end
          S_DEV_ACK:
            if (rw) begin
              tx       <= rd_byte[6:0];
              sda_pull <= ~rd_byte[7];
              state    <= S_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_WORD;
            end
          S_WORD:
            if (cnt == 4'd8) begin
              cnt      <= '0;
              ptr      <= sh[AW-1:0];
              sda_pull <= 1'b1;
              state    <= S_WORD_ACK;
            end
          S_WORD_ACK: begin
            sda_pull <= 1'b0;
            state    <= S_DATA;
          end
          S_DATA:
            if (cnt == 4'd8) begin
              cnt      <= '0;
              ptr      <= ptr + 1'b1;
              sda_pull <= 1'b1;
              state    <= S_DATA_ACK;
            end
          S_DATA_ACK: begin
            sda_pull <= 1'b0;
            state    <= S_DATA;
          end
          S_TX:
            if (cnt == 4'd8) begin
              cnt      <= '0;
              sda_pull <= 1'b0;
              ptr      <= ptr + 1'b1;
              state    <= S_TX_ACK;
            end else begin
              tx       <= {tx[5:0], 1'b0};
              sda_pull <= ~tx[6];
            end
          S_TX_ACK:
            if (mack) begin
              tx       <= rd_byte[6:0];
              sda_pull <= ~rd_byte[7];
              state    <= S_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_WAIT;
            end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       sda_pull,
  input logic       standby,
  input logic       start_det,
  input logic       stop_det,
  input logic [3:0] state
);
  localparam logic [3:0] DEV_ACK = 4'd2, WORD_ACK = 4'd4, DATA_ACK = 4'd6, WAITS = 4'd9;

  p_mute_in_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sda_pull);

  p_ack_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DEV_ACK || state == WORD_ACK || state == DATA_ACK) |-> sda_pull);

  p_quiet_after_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAITS) |-> !sda_pull);

  p_stop_to_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> standby);

  p_start_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !standby);

  p_pull_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_q);
endmodule

bind spd_eeprom_slave spd_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_pull(sda_pull),
  .standby(standby), .start_det(start_det), .stop_det(stop_det), .state(state)
);

// File: tb/sim_spd_eeprom_slave.sv
module sim_spd_eeprom_slave;
  localparam int Q = 5;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, standby;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_pull;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  spd_eeprom_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .strap(STRAP), .sda_pull(sda_pull), .standby(standby)
  );

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(2*Q);
  endtask

  task automatic send_bit(bit b);
    m_sda = b; wt(Q); m_scl = 1'b1; wt(2*Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    ack = (sda_bus == 1'b0);
    wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
      d[i] = sda_bus;
      wt(Q); m_scl = 1'b0; wt(Q);
    end
    send_bit(!give_ack);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    wt(5); rst_n = 1'b1; wt(3);
    chk(standby == 1'b1, "R1 standby", 32'(standby), 1);
    chk(sda_pull == 1'b0, "R1 pull", 32'(sda_pull), 0);

    // R2: address byte without a start
    m_scl = 1'b0; wt(Q);
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(ack == 1'b0, "R2 ack without start", 32'(ack), 0);
    chk(standby == 1'b1, "R2 standby", 32'(standby), 1);
    bus_stop;

    // R3: sweep strap field and a wrong type code
    for (int a = 0; a < 9; a++) begin
      logic [7:0] ab;
      bit hit;
      ab  = (a < 8) ? {4'b1010, 3'(a), 1'b0} : {4'b1011, STRAP, 1'b0};
      hit = (a < 8) && (3'(a) == STRAP);
      bus_start;
      send_byte(ab, ack);
      chk(ack == hit, "R3 address match", 32'(ack), 32'(hit));
      if (!hit) begin
        chk(standby == 1'b1, "R3 idle after mismatch", 32'(standby), 1);
        send_byte(8'h00, ack);
        chk(ack == 1'b0, "R3 mute after mismatch", 32'(ack), 0);
      end
      bus_stop;
    end

    // R4/R5: fill whole memory
    bus_start;
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h00, ack);
    chk(ack == 1'b1, "R4 word address ack", 32'(ack), 1);
    for (int i = 0; i < 256; i++) begin
      send_byte(pat(i), ack);
      model[i] = pat(i);
      chk(ack == 1'b1, "R4 data ack", 32'(ack), 1);
    end
    bus_stop;
    chk(standby == 1'b1, "R8 standby after write", 32'(standby), 1);

    // R5: write across the wrap
    bus_start;
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'hFE, ack);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'hA0 + 8'(k), ack);
      model[(254 + k) & 255] = 8'hA0 + 8'(k);
    end
    bus_stop;

    // R9/R6: pointer load, repeated start, read 20
    bus_start;
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h10, ack);
    bus_start;
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(ack == 1'b1, "R9 read address after repeated start", 32'(ack), 1);
    for (int i = 0; i < 20; i++) begin
      recv_byte(i != 19, d);
      chk(d == model[16 + i], "R6 R9 random read", 32'(d), 32'(model[16 + i]));
    end
    bus_stop;

    // R6: read with no pointer load continues at 0x24
    bus_start;
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d == model[8'h24], "R6 current pointer read", 32'(d), 32'(model[8'h24]));
    bus_stop;

    // R5/R6: read across the wrap from 0xF8
    bus_start;
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'hF8, ack);
    bus_start;
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, d);
      chk(d == model[(248 + i) & 255], "R5 R6 wrap read", 32'(d), 32'(model[(248 + i) & 255]));
    end
    bus_stop;

    // R7: nack ends sending; extra clocks see released line
    bus_start;
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d == model[8'h08], "R7 byte before nack", 32'(d), 32'(model[8'h08]));
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R7 silent after nack", 32'(d), 32'hFF);
    chk(standby == 1'b0, "R7 waiting for stop", 32'(standby), 0);
    bus_stop;
    chk(standby == 1'b1, "R8 standby after nack stop", 32'(standby), 1);

    // R8/R5: stop in the middle of a data byte
    bus_start;
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h40, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop;
    chk(standby == 1'b1, "R8 standby mid byte", 32'(standby), 1);

    // Full readback
    bus_start;
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h00, ack);
    bus_start;
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    for (int i = 0; i < 256; i++) begin
      recv_byte(i != 255, d);
      chk(d == model[i], "R5 R6 full readback", 32'(d), 32'(model[i]));
    end
    bus_stop;
    chk(sda_pull == 1'b0, "R8 released at end", 32'(sda_pull), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule